// File: doc/BRIEF.md
# Accumulator and Extension Shift Unit

This block carries out the two shift instruction families of a 16-bit processor on its working pair: the accumulator and the extension register beside it. A 5-bit operation code selects shifting left or right. A 2-bit modifier selects the variant. Left variants shift the accumulator alone or the 32-bit pair, or shift while counting until the value is normalised. Right variants are arithmetic shifts of the accumulator alone or of the pair, plus a 32-bit rotate right.

A request is accepted with a one-cycle `start`. The unit loads the operands and the 6-bit shift count, then moves one bit position per clock. It raises `done` for a single cycle once the count is used up, or once a counting variant finds the value normalised. The updated registers, the carry indicator and the remaining count stay on the outputs until the next request.

Top module: `acc_shift_unit`

## Requirements
- R1: With opcode 00010 and modifier 00, the accumulator is shifted left by the count with zeros entering at bit 0, and the extension is left unchanged.
- R2: With opcode 00010 and modifier 10, the 32-bit value {accumulator, extension} is shifted left by the count with zero fill, so extension bit 15 enters accumulator bit 0.
- R3: With opcode 00011 and modifier 00 or 11, the accumulator alone is shifted right arithmetically (bit 15 replicated), and the extension is unchanged.
- R4: With opcode 00011 and modifier 10, {accumulator, extension} is shifted right arithmetically as one 32-bit value, so accumulator bit 0 enters extension bit 15.
- R5: With opcode 00011 and modifier 01, {accumulator, extension} is rotated right, so extension bit 0 enters accumulator bit 15.
- R6: Carry is cleared when a request is accepted. Each left step loads carry with the bit leaving accumulator bit 15. Right shifts and the rotate leave carry at 0.
- R7: With opcode 00010 and modifier 01 (accumulator only) or 11 (pair), the unit stops before any step where accumulator bits 15 and 14 differ. The count output then holds the unused count.
- R8: A counting variant whose operands are all zero uses the full count, ends with count output 0, and leaves the registers zero.
- R9: The unit performs one step per clock. After the loading edge, `done` rises at clock edge k+1, where k is the number of steps, and stays high for exactly one cycle.
- R10: A count of 0 raises `done` on the first edge after loading, with the registers unchanged and carry 0.
- R11: `start` is ignored while a request is in progress, and also when the opcode is neither 00010 nor 00011. An ignored request leaves all outputs unchanged and raises no `done`.
- R12: After reset the accumulator, extension, carry, count output and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a shift |
| opcode | input | 5 | Operation code: 00010 shifts left, 00011 shifts right |
| modifier | input | 2 | Variant select (bit 8 is the MSB, bit 9 the LSB) |
| count_in | input | 6 | Number of bit positions to shift |
| acc_in | input | 16 | Accumulator operand |
| ext_in | input | 16 | Extension operand |
| acc_out | output | 16 | Accumulator result |
| ext_out | output | 16 | Extension result |
| carry | output | 1 | Last bit shifted out of the top on left shifts |
| count_out | output | 6 | Remaining count |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is the early stop of the counting variants in the middle of a run. The accumulator has to become normalised after some steps but before the count runs out. When both operands are drawn uniformly, the value is normalised at once or almost at once. The stimulus therefore also builds operands with a chosen number of leading sign-copy bits, including a zero accumulator whose leading one sits in the extension. Each random draw is paired with a count both above and below that depth, so the stop point falls on either side of the count.

// File: rtl/acc_shift_pkg.sv
package acc_shift_pkg;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 6;
  localparam int OP_W   = 5;

  localparam logic [OP_W-1:0] OP_SHL = 5'b00010;
  localparam logic [OP_W-1:0] OP_SHR = 5'b00011;

  typedef enum logic [2:0] {
    V_NONE,
    V_LEFT_A,
    V_LEFT_AE,
    V_NORM_A,
    V_NORM_AE,
    V_RIGHT_A,
    V_RIGHT_AE,
    V_ROT_AE
  } shift_var_e;
endpackage

// File: rtl/shift_decode.sv
module shift_decode
  import acc_shift_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  input  logic [1:0]      modifier,
  output shift_var_e      variant
);
  always_comb begin
    variant = V_NONE;
    if (opcode == OP_SHL) begin
      unique case (modifier)
        2'b00:   variant = V_LEFT_A;
        2'b10:   variant = V_LEFT_AE;
        2'b01:   variant = V_NORM_A;
        default: variant = V_NORM_AE;
      endcase
    end else if (opcode == OP_SHR) begin
      unique case (modifier)
        2'b10:   variant = V_RIGHT_AE;
        2'b01:   variant = V_ROT_AE;
        default: variant = V_RIGHT_A;   // 00 and its duplicate 11
      endcase
    end
  end
endmodule

// File: rtl/shift_step.sv
module shift_step
  import acc_shift_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  shift_var_e     variant,
  input  logic [W-1:0]   acc,
  input  logic [W-1:0]   ext,
  output logic [W-1:0]   acc_n,
  output logic [W-1:0]   ext_n,
  output logic           cout,
  output logic           is_left,
  output logic           is_norm,
  output logic           norm_hit
);
  assign is_left  = (variant == V_LEFT_A) || (variant == V_LEFT_AE) ||
                    (variant == V_NORM_A) || (variant == V_NORM_AE);
  assign is_norm  = (variant == V_NORM_A) || (variant == V_NORM_AE);
  assign norm_hit = acc[W-1] ^ acc[W-2];

  always_comb begin
    acc_n = acc;
    ext_n = ext;
    cout  = 1'b0;
    unique case (variant)
      V_LEFT_A, V_NORM_A: begin
        acc_n = {acc[W-2:0], 1'b0};
        cout  = acc[W-1];
      end
      V_LEFT_AE, V_NORM_AE: begin
        {acc_n, ext_n} = {acc[W-2:0], ext, 1'b0};
        cout           = acc[W-1];
      end
      V_RIGHT_A:  acc_n = {acc[W-1], acc[W-1:1]};
      V_RIGHT_AE: {acc_n, ext_n} = {acc[W-1], acc, ext[W-1:1]};
      V_ROT_AE:   {acc_n, ext_n} = {ext[0], acc, ext[W-1:1]};
      default: ;
    endcase
  end
endmodule

// File: rtl/shift_ctrl.sv
module shift_ctrl #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          req_valid,
  input  logic [CW-1:0] count_in,
  input  logic          norm_stop,
  output logic          load_en,
  output logic          step_en,
  output logic          busy,
  output logic [CW-1:0] cnt,
  output logic          done
);
  logic          busy_q, busy_d, done_q, done_d, stop;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    load_en = start && req_valid && !busy_q;
    stop    = busy_q && ((cnt_q == '0) || norm_stop);
    step_en = busy_q && !stop;
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    done_d  = stop;
    if (load_en) begin
      busy_d = 1'b1;
      cnt_d  = count_in;
    end else if (stop) begin
      busy_d = 1'b0;
    end else if (step_en) begin
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign cnt  = cnt_q;
  assign done = done_q;

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> (cnt_q == $past(cnt_q) - 1'b1));
  assert_zero_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && count_in == '0) |=> ##1 done);
  assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !stop) |=> busy_q);
endmodule

// File: rtl/acc_shift_unit.sv
module acc_shift_unit
  import acc_shift_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int CW = CNT_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [OP_W-1:0] opcode,
  input  logic [1:0]      modifier,
  input  logic [CW-1:0]   count_in,
  input  logic [W-1:0]    acc_in,
  input  logic [W-1:0]    ext_in,
  output logic [W-1:0]    acc_out,
  output logic [W-1:0]    ext_out,
  output logic            carry,
  output logic [CW-1:0]   count_out,
  output logic            done
);
  shift_var_e    dec_var, var_q, var_d;
  logic [W-1:0]  acc_q, acc_d, ext_q, ext_d, acc_s, ext_s;
  logic          carry_q, carry_d, cout, is_left, is_norm, norm_hit;
  logic          load_en, step_en, busy;

  shift_decode u_decode (
    .opcode  (opcode),
    .modifier(modifier),
    .variant (dec_var)
  );

  shift_step #(.W(W)) u_step (
    .variant (var_q),
    .acc     (acc_q),
    .ext     (ext_q),
    .acc_n   (acc_s),
    .ext_n   (ext_s),
    .cout    (cout),
    .is_left (is_left),
    .is_norm (is_norm),
    .norm_hit(norm_hit)
  );

  shift_ctrl #(.CW(CW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .req_valid(dec_var != V_NONE),
    .count_in (count_in),
    .norm_stop(is_norm && norm_hit),
    .load_en  (load_en),
    .step_en  (step_en),
    .busy     (busy),
    .cnt      (count_out),
    .done     (done)
  );

  always_comb begin
    acc_d   = acc_q;
    ext_d   = ext_q;
    carry_d = carry_q;
    var_d   = var_q;
    if (load_en) begin
      acc_d   = acc_in;
      ext_d   = ext_in;
      carry_d = 1'b0;
      var_d   = dec_var;
    end else if (step_en) begin
      acc_d = acc_s;
      ext_d = ext_s;
      if (is_left) carry_d = cout;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      ext_q   <= '0;
      carry_q <= 1'b0;
      var_q   <= V_NONE;
    end else begin
      acc_q   <= acc_d;
      ext_q   <= ext_d;
      carry_q <= carry_d;
      var_q   <= var_d;
    end
  end

  assign acc_out = acc_q;
  assign ext_out = ext_q;
  assign carry   = carry_q;

  assert_carry_right_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !is_left) |-> !carry_q);
  assert_ext_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (var_q == V_LEFT_A || var_q == V_NORM_A || var_q == V_RIGHT_A))
      |=> $stable(ext_q));
  assert_rotate_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && var_q == V_ROT_AE)
      |=> ($countones({acc_q, ext_q}) == $countones($past({acc_q, ext_q}))));
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !load_en) |=> ($stable(acc_q) && $stable(ext_q) && $stable(carry_q)));
endmodule

// File: tb/acc_shift_unit_bench.sv
module acc_shift_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  opcode = '0;
  logic [1:0]  modifier = '0;
  logic [5:0]  count_in = '0;
  logic [15:0] acc_in = '0, ext_in = '0;
  logic [15:0] acc_out, ext_out;
  logic        carry, done;
  logic [5:0]  count_out;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  acc_shift_unit u_acc_shift_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .modifier(modifier), .count_in(count_in), .acc_in(acc_in),
    .ext_in(ext_in), .acc_out(acc_out), .ext_out(ext_out),
    .carry(carry), .count_out(count_out), .done(done)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [4:0] op, input logic [1:0] md);
    if (op == 5'b00010) begin
      case (md)
        2'b00:   return "R1";
        2'b10:   return "R2";
        default: return "R7";
      endcase
    end
    case (md)
      2'b10:   return "R4";
      2'b01:   return "R5";
      default: return "R3";
    endcase
  endfunction

  // Independent reference model of the shift families
  task automatic model(input logic [4:0] op, input logic [1:0] md,
                       input logic [5:0] n, input logic [15:0] a0,
                       input logic [15:0] e0,
                       output logic [15:0] a, output logic [15:0] e,
                       output logic c, output logic [5:0] rem,
                       output int steps);
    logic left, both, norm, rot;
    logic [31:0] p;
    left  = (op == 5'b00010);
    both  = left ? md[1] : (md == 2'b10 || md == 2'b01);
    norm  = left && md[0];
    rot   = !left && (md == 2'b01);
    a = a0; e = e0; c = 1'b0; rem = n; steps = 0;
    while (rem != 0) begin
      if (norm && (a[15] != a[14])) break;
      p = {a, e};
      if (left) begin
        c = a[15];
        if (both) p = p << 1; else p = {a << 1, e};
      end else if (rot) begin
        p = {p[0], p[31:1]};
      end else if (both) begin
        p = {p[31], p[31:1]};
      end else begin
        p = {a[15], a[15:1], e};
      end
      a = p[31:16]; e = p[15:0];
      rem--; steps++;
    end
  endtask

  task automatic run_op(input logic [4:0] op, input logic [1:0] md,
                        input logic [5:0] n, input logic [15:0] a0,
                        input logic [15:0] e0, input bit intrude);
    logic [15:0] ea, ee; logic ec; logic [5:0] er; int k, cyc;
    string rq;
    model(op, md, n, a0, e0, ea, ee, ec, er, k);
    rq = req_of(op, md);
    @(negedge clk);
    opcode = op; modifier = md; count_in = n; acc_in = a0; ext_in = e0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 200) begin
      if (intrude && cyc == 1) begin
        // R11: a second request during a run must be ignored
        opcode = 5'b00010; modifier = 2'b00; count_in = 6'd3;
        acc_in = ~a0; ext_in = ~e0; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    // R9: done at edge k+1 after the loading edge (R10 when n is 0)
    check((n == 0) ? "R10" : "R9", "done cycle", cyc, k + 1);
    check(intrude ? "R11" : rq, "acc", acc_out, ea);
    check(intrude ? "R11" : rq, "ext", ext_out, ee);
    check("R6", "carry", carry, ec);
    check(md[0] && op == 5'b00010 ? "R7" : rq, "count", count_out, er);
    @(negedge clk);
    check("R9", "done pulse width", done, 1'b0);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] keep_a, keep_e;
    int unsigned seed;
    seed = 32'd1130;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12", "acc", acc_out, 16'h0);
    check("R12", "ext", ext_out, 16'h0);
    check("R12", "carry", carry, 1'b0);
    check("R12", "count", count_out, 6'h0);
    check("R12", "done", done, 1'b0);

    // Directed corner cases
    run_op(5'b00010, 2'b00, 6'd1, 16'h8001, 16'h1234, 0);  // R1 carry out
    run_op(5'b00010, 2'b10, 6'd4, 16'h0F00, 16'hF000, 0);  // R2
    run_op(5'b00011, 2'b00, 6'd3, 16'h8000, 16'h5555, 0);  // R3
    run_op(5'b00011, 2'b11, 6'd3, 16'h8000, 16'h5555, 0);  // R3 duplicate code
    run_op(5'b00011, 2'b10, 6'd1, 16'h0001, 16'h0000, 0);  // R4
    run_op(5'b00011, 2'b01, 6'd1, 16'h0000, 16'h0001, 0);  // R5
    run_op(5'b00011, 2'b01, 6'd32, 16'hA5C3, 16'h1E0F, 0); // R5 full turn
    run_op(5'b00010, 2'b01, 6'd20, 16'h0010, 16'h0000, 0); // R7 early stop
    run_op(5'b00010, 2'b11, 6'd40, 16'h0000, 16'h0100, 0); // R7 via extension
    run_op(5'b00010, 2'b01, 6'd5, 16'h4000, 16'h0000, 0);  // R7 stops at once
    run_op(5'b00010, 2'b01, 6'd63, 16'h0000, 16'h0000, 0); // R8
    run_op(5'b00010, 2'b11, 6'd17, 16'h0000, 16'h0000, 0); // R8
    run_op(5'b00010, 2'b10, 6'd0, 16'h9ABC, 16'hDEF0, 0);  // R10
    run_op(5'b00011, 2'b10, 6'd6, 16'h8421, 16'h1248, 1);  // R11 busy

    // R11: non-shift opcode is ignored
    keep_a = acc_out; keep_e = ext_out;
    @(negedge clk);
    opcode = 5'b11000; modifier = 2'b00; count_in = 6'd4;
    acc_in = 16'hFFFF; ext_in = 16'hFFFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      logic seen;
      seen = 1'b0;
      for (int i = 0; i < 6; i++) begin
        if (done) seen = 1'b1;
        @(negedge clk);
      end
      check("R11", "no done on bad opcode", seen, 1'b0);
    end
    check("R11", "acc kept", acc_out, keep_a);
    check("R11", "ext kept", ext_out, keep_e);

    // Constrained random mix, with shaped operands for the counting variants
    for (int i = 0; i < 150; i++) begin
      logic [4:0] op; logic [1:0] md; logic [5:0] n;
      logic [31:0] v; int lead;
      op = ($urandom % 2) ? 5'b00010 : 5'b00011;
      md = 2'($urandom);
      v  = $urandom;
      if (op == 5'b00010 && md[0] && ($urandom % 2)) begin
        lead = $urandom % 31;
        v = (v | 32'h1) >> lead;
        if ($urandom % 2) v = ~v;
        n = 6'(lead + ($urandom % 5) - 2);
      end else begin
        n = 6'($urandom);
      end
      run_op(op, md, n, v[31:16], v[15:0], 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule